// File: doc/BRIEF.md
# Indexed NVRAM Access Port with Region Locks

This block gives a host a four-byte I/O window onto a byte-wide non-volatile store of up to 64 KB. The storage array itself is outside the block; the port drives its address, write enable, write data and read enable, and it takes the array's read byte back. The host first loads a 16-bit pointer through two byte registers, one for the low byte and one for the high byte. It then reads or writes the byte the pointer selects through a separate data offset.

A data write clears the pointer, so the next transfer starts again from address zero unless the host reloads it. A data read leaves the pointer where it is. Two 16-byte windows at the bottom of the store can each be shut by a lock input. A shut window neither accepts writes nor returns its contents; a read of it gives 0xFF. Addresses at or beyond the configured memory size behave the same way.

All locations, including those a system may use for clock or calendar fields, are plain storage here. Read data is registered and holds its value until the next host read.

Top module: `nvidx_port`

## Requirements
- R1: A host write to offset 0 loads the data byte into bits 7:0 of the pointer and keeps bits 15:8 unchanged.
- R2: A host write to offset 1 loads the data byte into bits 15:8 of the pointer and keeps bits 7:0 unchanged.
- R3: A host write to offset 3 stores the data byte at the pointer address when that access is allowed. After any write to offset 3, the pointer is 0x0000, whether or not the store took place.
- R4: A host read of offset 3 returns the byte at the pointer address and leaves the pointer unchanged, so repeated reads return the same byte.
- R5: A host read of offset 0, 1 or 2 returns 0xFF. A host write to offset 2 changes neither the pointer nor the storage.
- R6: While lock bit 0, as sampled on the previous clock, is 1, addresses 0x20 to 0x2F are blocked. A read of them returns 0xFF and a write to them leaves storage unchanged. Addresses 0x1F and 0x30 are not affected by lock bit 0.
- R7: While lock bit 1, as sampled on the previous clock, is 1, addresses 0x30 to 0x3F are blocked in the same way. Addresses 0x2F and 0x40 are not affected by lock bit 1.
- R8: A pointer value at or above MEM_BYTES blocks the access. A write changes no storage location, including the location it would alias to, and a read returns 0xFF. MEM_BYTES-1 is accessible.
- R9: While reset is asserted, the pointer is 0x0000, both lock states are 0, read data is 0xFF and no storage write is issued. The storage contents are left untouched.
- R10: Read data changes one clock after a read strobe and keeps its value while no read strobe is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host_ofs | input | 2 | Host offset within the window (0 pointer low, 1 pointer high, 2 spare, 3 data) |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| lock_in | input | LOCK_REGIONS | Per-window lock request, sampled every clock |
| host_rdata | output | 8 | Registered host read data |
| mem_addr | output | MEM_AW | Storage address (pointer truncated to the array width) |
| mem_we | output | 1 | Storage write enable |
| mem_wdata | output | 8 | Storage write data |
| mem_re | output | 1 | Storage read enable |
| mem_rdata | input | 8 | Storage read data, combinational from mem_addr |

## Verification
The store is preloaded with a pattern that depends on both pointer bytes. This makes a read after a single low-byte or high-byte load show whether the other byte was kept, and a read after a data write show whether the pointer was cleared. Lock checks probe each window's first and last address and the neighbours just outside it, with each lock bit set on its own, which tells a correct window edge from an off-by-one. Out-of-range accesses read the aliased low address back after a write beyond MEM_BYTES, which separates a true range check from plain truncation. A data-write strobe held during reset shows whether stores are gated while the block is held.

// File: rtl/nvidx_pkg.sv
package nvidx_pkg;

  typedef enum logic [1:0] {
    OFS_PTR_LO = 2'd0,
    OFS_PTR_HI = 2'd1,
    OFS_SPARE  = 2'd2,
    OFS_DATA   = 2'd3
  } host_ofs_e;

  localparam logic [7:0] FILL_BYTE = 8'hFF;

  typedef struct packed {
    logic load_lo;
    logic load_hi;
    logic data_wr;
    logic data_rd;
    logic any_rd;
  } host_op_t;

endpackage

// File: rtl/nvidx_decode.sv
module nvidx_decode
  import nvidx_pkg::*;
(
  input  logic       rst_n,
  input  logic [1:0] host_ofs,
  input  logic       host_wr,
  input  logic       host_rd,
  output host_op_t   op
);

  logic wr_en;
  logic rd_en;

  always_comb begin
    wr_en      = host_wr & rst_n;
    rd_en      = host_rd & rst_n;
    op.load_lo = wr_en & (host_ofs == OFS_PTR_LO);
    op.load_hi = wr_en & (host_ofs == OFS_PTR_HI);
    op.data_wr = wr_en & (host_ofs == OFS_DATA);
    op.data_rd = rd_en & (host_ofs == OFS_DATA);
    op.any_rd  = rd_en;
  end

endmodule

// File: rtl/nvidx_ptr.sv
module nvidx_ptr
  import nvidx_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  host_op_t         op,
  input  logic [7:0]       wdata,
  output logic [PTR_W-1:0] ptr_q
);

  localparam int HI_W = PTR_W - 8;

  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = op.load_lo | op.load_hi | op.data_wr;
    if (op.data_wr) begin
      ptr_d = '0;
    end else if (op.load_hi) begin
      ptr_d = {wdata[HI_W-1:0], ptr_q[7:0]};
    end else if (op.load_lo) begin
      ptr_d = {ptr_q[PTR_W-1:8], wdata};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

endmodule

// File: rtl/nvidx_guard.sv
module nvidx_guard #(
  parameter int MEM_BYTES    = 8192,
  parameter int LOCK_REGIONS = 2,
  parameter int LOCK_BASE    = 32,
  parameter int LOCK_SPAN    = 16,
  parameter int PTR_W        = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LOCK_REGIONS-1:0] lock_in,
  input  logic [PTR_W-1:0]        ptr,
  output logic [LOCK_REGIONS-1:0] lock_q,
  output logic                    access_ok
);

  localparam logic [31:0] SIZE_W = 32'(MEM_BYTES);

  logic [LOCK_REGIONS-1:0] lock_d;
  logic [LOCK_REGIONS-1:0] hit;
  logic [31:0]             ptr_w;
  logic                    in_range;

  assign ptr_w = 32'(ptr);

  always_comb begin
    lock_d = lock_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
    end else begin
      lock_q <= lock_d;
    end
  end

  for (genvar g = 0; g < LOCK_REGIONS; g++) begin : g_window
    localparam logic [31:0] WIN_LO = 32'(LOCK_BASE + g * LOCK_SPAN);
    localparam logic [31:0] WIN_HI = 32'(LOCK_BASE + (g + 1) * LOCK_SPAN);
    assign hit[g] = (ptr_w >= WIN_LO) && (ptr_w < WIN_HI);
  end

  always_comb begin
    in_range  = ptr_w < SIZE_W;
    access_ok = in_range && !(|(hit & lock_q));
  end

endmodule

// File: rtl/nvidx_rdpath.sv
module nvidx_rdpath
  import nvidx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  host_op_t   op,
  input  logic       access_ok,
  input  logic [7:0] mem_rdata,
  output logic [7:0] rdata_q
);

  logic [7:0] rdata_d;

  always_comb begin
    rdata_d = rdata_q;
    if (op.any_rd) begin
      rdata_d = (op.data_rd && access_ok) ? mem_rdata : FILL_BYTE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= FILL_BYTE;
    end else if (op.any_rd) begin
      rdata_q <= rdata_d;
    end
  end

endmodule

// File: rtl/nvidx_port.sv
module nvidx_port
  import nvidx_pkg::*;
#(
  parameter int MEM_BYTES    = 8192,
  parameter int LOCK_REGIONS = 2,
  parameter int LOCK_BASE    = 32,
  parameter int LOCK_SPAN    = 16,
  parameter int MEM_AW       = $clog2(MEM_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              host_ofs,
  input  logic                    host_wr,
  input  logic                    host_rd,
  input  logic [7:0]              host_wdata,
  input  logic [LOCK_REGIONS-1:0] lock_in,
  output logic [7:0]              host_rdata,
  output logic [MEM_AW-1:0]       mem_addr,
  output logic                    mem_we,
  output logic [7:0]              mem_wdata,
  output logic                    mem_re,
  input  logic [7:0]              mem_rdata
);

  localparam int PTR_W = 16;

  host_op_t                op;
  logic [PTR_W-1:0]        ptr_q;
  logic [LOCK_REGIONS-1:0] lock_q;
  logic                    access_ok;

  nvidx_decode u_decode (
    .rst_n    (rst_n),
    .host_ofs (host_ofs),
    .host_wr  (host_wr),
    .host_rd  (host_rd),
    .op       (op)
  );

  nvidx_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .wdata (host_wdata),
    .ptr_q (ptr_q)
  );

  nvidx_guard #(
    .MEM_BYTES    (MEM_BYTES),
    .LOCK_REGIONS (LOCK_REGIONS),
    .LOCK_BASE    (LOCK_BASE),
    .LOCK_SPAN    (LOCK_SPAN),
    .PTR_W        (PTR_W)
  ) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_in   (lock_in),
    .ptr       (ptr_q),
    .lock_q    (lock_q),
    .access_ok (access_ok)
  );

  nvidx_rdpath u_rdpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .access_ok (access_ok),
    .mem_rdata (mem_rdata),
    .rdata_q   (host_rdata)
  );

  always_comb begin
    mem_addr  = ptr_q[MEM_AW-1:0];
    mem_wdata = host_wdata;
    mem_we    = op.data_wr & access_ok;
    mem_re    = op.data_rd & access_ok;
  end

endmodule

// File: rtl/nvidx_port_chk.sv
module nvidx_port_chk #(
  parameter int MEM_BYTES    = 8192,
  parameter int LOCK_REGIONS = 2,
  parameter int LOCK_BASE    = 32,
  parameter int LOCK_SPAN    = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [1:0]              host_ofs,
  input logic                    host_wr,
  input logic                    host_rd,
  input logic [7:0]              host_wdata,
  input logic [7:0]              host_rdata,
  input logic                    mem_we,
  input logic                    mem_re,
  input logic [15:0]             ptr_q,
  input logic [LOCK_REGIONS-1:0] lock_q
);

  a_r1_low_load: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_rd && host_ofs == 2'd0) |=>
      (ptr_q[7:0] == $past(host_wdata) && ptr_q[15:8] == $past(ptr_q[15:8])));

  a_r2_high_load: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_ofs == 2'd1) |=>
      (ptr_q[15:8] == $past(host_wdata) && ptr_q[7:0] == $past(ptr_q[7:0])));

  a_r3_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_ofs == 2'd3) |=> (ptr_q == 16'h0000));

  a_r4_read_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr) |=> $stable(ptr_q));

  a_r5_spare_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_ofs != 2'd3) |=> (host_rdata == 8'hFF));

  a_r8_no_oob_access: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> (32'(ptr_q) < 32'(MEM_BYTES)));

  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!mem_we && !mem_re && ptr_q == 16'h0000 && lock_q == '0));

  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));

  // R6 (window 0) and R7 (window 1): a locked window sees no storage access
  for (genvar g = 0; g < LOCK_REGIONS; g++) begin : g_lockchk
    localparam logic [31:0] WLO = 32'(LOCK_BASE + g * LOCK_SPAN);
    localparam logic [31:0] WHI = 32'(LOCK_BASE + (g + 1) * LOCK_SPAN);
    a_r6_r7_locked_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_we || mem_re) && lock_q[g]) |->
        !(32'(ptr_q) >= WLO && 32'(ptr_q) < WHI));
  end

endmodule

bind nvidx_port nvidx_port_chk #(
  .MEM_BYTES    (MEM_BYTES),
  .LOCK_REGIONS (LOCK_REGIONS),
  .LOCK_BASE    (LOCK_BASE),
  .LOCK_SPAN    (LOCK_SPAN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_ofs   (host_ofs),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .mem_we     (mem_we),
  .mem_re     (mem_re),
  .ptr_q      (ptr_q),
  .lock_q     (lock_q)
);

// File: tb/sim_nvidx_port.sv
module sim_nvidx_port;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_BYTES  = 8192;
  localparam int MEM_AW     = $clog2(MEM_BYTES);

  logic              clk;
  logic              rst_n;
  logic [1:0]        host_ofs;
  logic              host_wr;
  logic              host_rd;
  logic [7:0]        host_wdata;
  logic [1:0]        lock_in;
  logic [7:0]        host_rdata;
  logic [MEM_AW-1:0] mem_addr;
  logic              mem_we;
  logic [7:0]        mem_wdata;
  logic              mem_re;
  logic [7:0]        mem_rdata;

  logic [7:0] store [MEM_BYTES];
  logic       fill;
  int         total;
  int         bad;
  bit         done;

  nvidx_port #(.MEM_BYTES(MEM_BYTES)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_ofs   (host_ofs),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .lock_in    (lock_in),
    .host_rdata (host_rdata),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .mem_re     (mem_re),
    .mem_rdata  (mem_rdata)
  );

  function automatic logic [7:0] pat(int i);
    return 8'(i) ^ 8'(i >> 5) ^ 8'h5A;
  endfunction

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // storage model: combinational read, clocked write
  always @(posedge clk) begin
    if (fill) begin
      for (int i = 0; i < MEM_BYTES; i++) store[i] <= pat(i);
    end else if (mem_we) begin
      store[mem_addr] <= mem_wdata;
    end
  end
  assign mem_rdata = store[mem_addr];

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic host_write(logic [1:0] ofs, logic [7:0] d);
    @(negedge clk);
    host_ofs = ofs; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(logic [1:0] ofs, output logic [7:0] v);
    @(negedge clk);
    host_ofs = ofs; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    v = host_rdata;
  endtask

  task automatic set_ptr(logic [15:0] a);
    host_write(2'd0, a[7:0]);
    host_write(2'd1, a[15:8]);
  endtask

  task automatic peek(logic [15:0] a, output logic [7:0] v);
    set_ptr(a);
    host_read(2'd3, v);
  endtask

  task automatic set_locks(logic [1:0] v);
    @(negedge clk);
    lock_in = v;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [7:0] v;
    check("R9 rdata after reset", host_rdata, 8'hFF);
    host_read(2'd3, v);
    check("R9 pointer zero after reset", v, pat(0));
  endtask

  task automatic t_data_write();
    logic [7:0] v;
    set_ptr(16'h0123);
    host_write(2'd3, 8'hC3);
    host_read(2'd3, v);
    check("R3 pointer cleared after data write", v, pat(0));
    peek(16'h0123, v);
    check("R3 stored byte", v, 8'hC3);
    host_read(2'd3, v);
    check("R4 repeat read same byte", v, 8'hC3);
  endtask

  task automatic t_byte_loads();
    logic [7:0] v;
    set_ptr(16'h0456);
    host_write(2'd0, 8'h78);
    host_read(2'd3, v);
    check("R1 low byte load keeps high", v, pat(16'h0478));
    host_write(2'd1, 8'h01);
    host_read(2'd3, v);
    check("R2 high byte load keeps low", v, pat(16'h0178));
  endtask

  task automatic t_spare_offsets();
    logic [7:0] v;
    set_ptr(16'h0200);
    host_read(2'd0, v); check("R5 read offset 0", v, 8'hFF);
    host_read(2'd1, v); check("R5 read offset 1", v, 8'hFF);
    host_read(2'd2, v); check("R5 read offset 2", v, 8'hFF);
    host_write(2'd2, 8'h99);
    host_read(2'd3, v);
    check("R5 offset 2 write ignored", v, pat(16'h0200));
  endtask

  task automatic t_lock0();
    logic [7:0] v;
    set_ptr(16'h0025);
    host_write(2'd3, 8'h11);
    set_locks(2'b01);
    peek(16'h0025, v); check("R6 locked read", v, 8'hFF);
    host_write(2'd3, 8'h22);
    host_read(2'd3, v);
    check("R3 pointer cleared after blocked write", v, pat(0));
    peek(16'h0020, v); check("R6 first locked address", v, 8'hFF);
    peek(16'h002F, v); check("R6 last locked address", v, 8'hFF);
    peek(16'h001F, v); check("R6 below window", v, pat(16'h001F));
    peek(16'h0030, v); check("R6 above window", v, pat(16'h0030));
    set_locks(2'b00);
    peek(16'h0025, v); check("R6 blocked write left storage", v, 8'h11);
  endtask

  task automatic t_lock1();
    logic [7:0] v;
    set_locks(2'b10);
    peek(16'h0030, v); check("R7 first locked address", v, 8'hFF);
    peek(16'h003F, v); check("R7 last locked address", v, 8'hFF);
    peek(16'h0040, v); check("R7 above window", v, pat(16'h0040));
    peek(16'h002F, v); check("R7 below window", v, pat(16'h002F));
    set_ptr(16'h0033);
    host_write(2'd3, 8'h44);
    set_locks(2'b00);
    peek(16'h0033, v); check("R7 blocked write left storage", v, pat(16'h0033));
  endtask

  task automatic t_out_of_range();
    logic [7:0] v;
    set_ptr(16'h2005);
    host_write(2'd3, 8'hEE);
    peek(16'h0005, v); check("R8 no aliased write", v, pat(5));
    peek(16'h2005, v); check("R8 read past size", v, 8'hFF);
    peek(16'hFFFF, v); check("R8 read top pointer", v, 8'hFF);
    peek(16'h1FFF, v); check("R8 last valid address", v, pat(16'h1FFF));
  endtask

  task automatic t_hold();
    logic [7:0] v;
    peek(16'h0123, v);
    check("R10 read data one clock after strobe", v, 8'hC3);
    set_ptr(16'h0300);
    repeat (3) @(negedge clk);
    check("R10 read data held without strobe", host_rdata, 8'hC3);
  endtask

  task automatic t_reset_again();
    logic [7:0] v;
    set_ptr(16'h0300);
    @(negedge clk);
    rst_n = 1'b0;
    host_ofs = 2'd3; host_wdata = 8'h77; host_wr = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 rdata during reset", host_rdata, 8'hFF);
    host_wr = 1'b0;
    rst_n = 1'b1;
    host_read(2'd3, v);
    check("R9 no store during reset, pointer zero", v, pat(0));
    peek(16'h0123, v);
    check("R9 storage kept over reset", v, 8'hC3);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; fill = 1'b1;
    host_ofs = 2'd0; host_wr = 1'b0; host_rd = 1'b0;
    host_wdata = 8'h00; lock_in = 2'b00;
    repeat (3) @(negedge clk);
    fill = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_data_write();
    t_byte_loads();
    t_spare_offsets();
    t_lock0();
    t_lock1();
    t_out_of_range();
    t_hold();
    t_reset_again();
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

endmodule